// File: doc/BRIEF.md
# Triple-Sampling Serial Receiver

This block turns an asynchronous serial line back into characters. The line is idle high. A character starts with a low start bit. Then come seven or eight data bits, least significant first. An optional parity bit follows, and the frame ends with one or two high stop bits. The format and enable inputs are static controls that the companion transmitter also uses. A 16-bit rate value drives a phase accumulator that produces four rate ticks per bit time, so the system clock needs no particular frequency.

The line passes through a two-flop synchronizer and a falling-edge detector. Each bit is sampled at its first, second and third quarter, and a majority vote decides its value. Every frame ends in exactly one single-cycle event:
- ready, for a good character;
- parity error, for a character with bad parity;
- format error, for a character with a low stop bit.

An aborted character never shows up as ready. Buffering the data output and crossing into other clock domains are left to the surrounding logic.

The controller is a state machine with six states:
- IDLE waits for a falling edge (transition *edge-seen* to START).
- START votes the start bit. A high vote takes *false-start* to WAIT_HIGH; a low vote takes *start-ok* to DATA.
- DATA collects the character bits. After the last bit it takes *data-done* to PARITY when parity is enabled, or to STOP otherwise.
- PARITY takes *parity-done* to STOP.
- STOP checks each stop bit. A low stop bit takes *stop-bad* to WAIT_HIGH. With two stop bits, the first good one takes *stop-more* back to STOP. The last good one takes *frame-end* to WAIT_HIGH.
- WAIT_HIGH takes *line-high* to IDLE once the synchronized line is high.

Clearing the run input takes *halt* from any state to IDLE.

Top module: `serial_rx_vote`

## Requirements
- R1: During and after reset, rx_ready, rx_par_err and rx_fmt_err are low and rx_data is zero; all three event outputs are low in every cycle in which no event is due.
- R2: The accumulator adds rate_val every clock while a frame is in progress and is cleared while idle; each carry is a rate tick, and one bit time is four ticks. With T = 65536/rate_val clocks per tick and B bits in the frame up to the deciding bit (start bit included), the frame's event is visible right after the clock edge that comes 2 + 4·T·B edges after the first edge that samples the line low.
- R3: If the start bit votes high, the frame is dropped silently: no event is raised, and a later frame is received normally.
- R4: Each bit is sampled at 1/4, 2/4 and 3/4 of its bit time and decided by majority, so one corrupted sample in a bit, start bit included, does not change the result.
- R5: Data bits arrive least significant first. With wide_char=1 all eight bits appear on rx_data; with wide_char=0 seven bits appear on rx_data[6:0] and bit 7 is don't-care. rx_data changes only in a cycle in which rx_ready is high.
- R6: With par_en=1, the parity bit follows the data bits. par_odd=0 means even parity and par_odd=1 means odd parity, counted over the data bits and the parity bit. A mismatch gives a one-cycle rx_par_err pulse instead of rx_ready.
- R7: With par_en=0, no parity bit is expected, and rx_par_err stays low.
- R8: A stop bit voted low gives a one-cycle rx_fmt_err pulse at the end of that stop bit, and no ready and no parity error for that frame. With two_stop=1 both stop bits are checked.
- R9: While run=0 the line is ignored and all event outputs stay low. Once run returns to 1, a later frame is received normally.
- R10: After a frame ends or is aborted, a new frame starts only after the line has been high and then falls. A line held low after a format error starts no frame.
- R11: At most one of rx_ready, rx_par_err and rx_fmt_err is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input, idle high |
| run | input | 1 | Receiver enable; 0 holds the receiver idle |
| rate_val | input | 16 | Rate value added to the phase accumulator each clock |
| wide_char | input | 1 | 1: eight data bits, 0: seven data bits |
| par_en | input | 1 | 1: a parity bit is expected and checked |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| rx_data | output | 8 | Received character, valid while rx_ready is high |
| rx_ready | output | 1 | One-cycle pulse: good character received |
| rx_par_err | output | 1 | One-cycle pulse: character aborted for parity |
| rx_fmt_err | output | 1 | One-cycle pulse: character aborted for a low stop bit |

## Verification
The bench builds the block with its default parameters: eight data bits and a two-stage synchronizer. It runs mostly with rate value 4096, which gives an exact 16-clock tick, so every sample point and every event falls on a cycle the bench can predict. One frame runs at rate value 2048 to show that the bit time scales with the rate input. Because the timing is exact, the bench can corrupt a single sample at a known cycle to exercise the vote. It can also make a start pulse shorter than half a bit, hold the line low after a stop-bit failure, and switch run off while a frame is on the line.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_e;

    // rate ticks per bit time; samples are taken on the first three
    localparam int TICKS_PER_BIT = 4;
    localparam int TICK_CNT_W    = $clog2(TICKS_PER_BIT);

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign dout = chain_q[STAGES-1];
    assign fall = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/rx_rate_gen.sv
module rx_rate_gen #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [RATE_W-1:0] acc_q;
    logic [RATE_W:0]   sum;

    assign sum  = {1'b0, acc_q} + {1'b0, rate};
    assign tick = sum[RATE_W] & ~clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc_q <= '0;
        else if (clr) acc_q <= '0;
        else          acc_q <= sum[RATE_W-1:0];
    end

endmodule

// File: rtl/rx_vote3.sv
module rx_vote3 (
    input  logic [2:0] samp,
    output logic       bit_val
);
    assign bit_val = (samp[0] & samp[1]) | (samp[0] & samp[2]) | (samp[1] & samp[2]);
endmodule

// File: rtl/serial_rx_vote.sv
module serial_rx_vote
    import serial_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int RATE_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_val,
    input  logic              wide_char,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              rx_par_err,
    output logic              rx_fmt_err
);
    localparam int IDX_W = $clog2(DATA_W);

    rx_state_e state_q, state_d;

    logic                  line_s, fall, tick, vote, bit_end, par_bad;
    logic [TICK_CNT_W-1:0] sub_q;
    logic [IDX_W-1:0]      idx_q, last_idx;
    logic                  stop_q, par_q;
    logic [2:0]            samp_q;
    logic [DATA_W-1:0]     shift_q, char_mask;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s),
        .fall (fall)
    );

    rx_rate_gen #(.RATE_W(RATE_W)) u_rate (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  ((state_q == RX_IDLE) || (state_q == RX_WAIT_HIGH)),
        .rate (rate_val),
        .tick (tick)
    );

    rx_vote3 u_vote (
        .samp   (samp_q),
        .bit_val(vote)
    );

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            char_mask[i] = (i < DATA_W - 1) ? 1'b1 : wide_char;
        end
    end

    assign last_idx = wide_char ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
    assign bit_end  = tick && (sub_q == TICK_CNT_W'(TICKS_PER_BIT - 1));
    assign par_bad  = (^(shift_q & char_mask)) ^ par_q ^ par_odd;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:      if (fall) state_d = RX_START;
            RX_START:     if (bit_end) state_d = vote ? RX_WAIT_HIGH : RX_DATA;
            RX_DATA:      if (bit_end && idx_q == last_idx)
                              state_d = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY:    if (bit_end) state_d = RX_STOP;
            RX_STOP:      if (bit_end && (!vote || !two_stop || stop_q))
                              state_d = RX_WAIT_HIGH;
            RX_WAIT_HIGH: if (line_s) state_d = RX_IDLE;
            default:      state_d = RX_IDLE;
        endcase
        if (!run) state_d = RX_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // datapath and event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q      <= '0;
            idx_q      <= '0;
            stop_q     <= 1'b0;
            par_q      <= 1'b0;
            samp_q     <= '0;
            shift_q    <= '0;
            rx_data    <= '0;
            rx_ready   <= 1'b0;
            rx_par_err <= 1'b0;
            rx_fmt_err <= 1'b0;
        end else begin
            rx_ready   <= 1'b0;
            rx_par_err <= 1'b0;
            rx_fmt_err <= 1'b0;
            if (!run || state_q == RX_IDLE || state_q == RX_WAIT_HIGH) begin
                sub_q   <= '0;
                idx_q   <= '0;
                stop_q  <= 1'b0;
                samp_q  <= '0;
                shift_q <= '0;
            end else if (tick) begin
                sub_q <= sub_q + 1'b1;
                unique case (sub_q)
                    2'd0:    samp_q[0] <= line_s;
                    2'd1:    samp_q[1] <= line_s;
                    2'd2:    samp_q[2] <= line_s;
                    default: begin
                        unique case (state_q)
                            RX_DATA: begin
                                shift_q[idx_q] <= vote;
                                idx_q          <= idx_q + 1'b1;
                            end
                            RX_PARITY: par_q <= vote;
                            RX_STOP: begin
                                if (!vote)                     rx_fmt_err <= 1'b1;
                                else if (two_stop && !stop_q)  stop_q     <= 1'b1;
                                else if (par_en && par_bad)    rx_par_err <= 1'b1;
                                else begin
                                    rx_ready <= 1'b1;
                                    rx_data  <= shift_q & char_mask;
                                end
                            end
                            default: ;
                        endcase
                    end
                endcase
            end
        end
    end

    // R11
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_ready, rx_par_err, rx_fmt_err}));

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !(rx_ready || rx_par_err || rx_fmt_err));

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> rx_ready);

    // R7
    par_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_par_err |-> $past(par_en));

    // R8
    fmt_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fmt_err |-> $past(state_q) == RX_STOP);

endmodule

// File: tb/tb_serial_rx_vote.sv
`timescale 1ns/1ps
module tb_serial_rx_vote;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic        run = 1'b1;
    logic [15:0] rate_val = 16'd4096;
    logic        wide_char = 1'b1;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic        two_stop = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_ready, rx_par_err, rx_fmt_err;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    // expected events: cycle, kind (1 ready, 2 parity, 3 format), data, width, tag
    int    ex_cyc[$];
    int    ex_kind[$];
    int    ex_data[$];
    int    ex_wide[$];
    string ex_tag[$];

    serial_rx_vote dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .run(run), .rate_val(rate_val),
        .wide_char(wide_char), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .rx_data(rx_data), .rx_ready(rx_ready), .rx_par_err(rx_par_err), .rx_fmt_err(rx_fmt_err)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // per-cycle comparison against the behavioural expectation
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int kind;
            string tag;
            kind = 0;
            tag = "R1";
            if (ex_cyc.size() > 0 && ex_cyc[0] == cyc) begin
                kind = ex_kind[0];
                tag  = ex_tag[0];
            end
            checks++;
            if (rx_ready !== (kind == 1) || rx_par_err !== (kind == 2) || rx_fmt_err !== (kind == 3)) begin
                errors++;
                $display("FAIL %s cycle %0d: events rdy/par/fmt=%b%b%b expected kind %0d",
                         tag, cyc, rx_ready, rx_par_err, rx_fmt_err, kind);
            end
            if (kind == 1) begin
                logic [7:0] m;
                m = (ex_wide[0] != 0) ? 8'hFF : 8'h7F;
                checks++;
                if ((rx_data & m) !== (8'(ex_data[0]) & m)) begin
                    errors++;
                    $display("FAIL %s data actual %h expected %h", tag, rx_data & m, 8'(ex_data[0]) & m);
                end
            end
            if (kind != 0) begin
                void'(ex_cyc.pop_front()); void'(ex_kind.pop_front());
                void'(ex_data.pop_front()); void'(ex_wide.pop_front());
                void'(ex_tag.pop_front());
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_line = 1'b1;
        end
    endtask

    // stop_low: index of a low stop bit (-1 none); glitch_bit: frame bit whose first sample is inverted
    task automatic send(input logic [7:0] d, input bit wide, input bit pen, input bit podd,
                        input bit two, input bit flip_par, input int stop_low,
                        input int glitch_bit, input int hold_low, input bit expect_evt,
                        input string tag);
        int bits[$];
        int tck, bitc, nb, b_dec, kind, c0;
        logic [7:0] m;
        wide_char = wide; par_en = pen; par_odd = podd; two_stop = two;
        tck  = 65536 / int'(rate_val);
        bitc = 4 * tck;
        nb   = wide ? 8 : 7;
        m    = wide ? 8'hFF : 8'h7F;
        bits.push_back(0);
        for (int i = 0; i < nb; i++) bits.push_back(int'(d[i]));
        if (pen) bits.push_back(int'((^(d & m)) ^ podd ^ flip_par));
        b_dec = bits.size();
        kind  = 0;
        for (int s = 0; s < (two ? 2 : 1); s++) begin
            bits.push_back((s == stop_low) ? 0 : 1);
            if (kind == 0) begin
                b_dec++;
                if (s == stop_low) kind = 3;
            end
        end
        if (kind == 0) kind = (pen && flip_par) ? 2 : 1;
        c0 = 0;
        for (int t = 0; t < bits.size() * bitc; t++) begin
            @(negedge clk);
            if (t == 0) begin
                c0 = cyc;
                if (expect_evt) begin
                    ex_cyc.push_back(c0 + 3 + bitc * b_dec);
                    ex_kind.push_back(kind);
                    ex_data.push_back(int'(d));
                    ex_wide.push_back(int'(wide));
                    ex_tag.push_back(tag);
                end
            end
            rx_line = 1'(bits[t / bitc]) ^ ((glitch_bit >= 0) && (t == glitch_bit * bitc + tck));
        end
        for (int i = 0; i < hold_low; i++) begin
            @(negedge clk);
            rx_line = 1'b0;
        end
        idle(40);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (rx_ready !== 1'b0 || rx_par_err !== 1'b0 || rx_fmt_err !== 1'b0 || rx_data !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset outputs %b%b%b data %h expected 000 data 00",
                     rx_ready, rx_par_err, rx_fmt_err, rx_data);
        end
        rst_n = 1'b1;
        idle(20);

        // R5 eight bits, no parity, one stop; R7 parity output stays low
        send(8'hA5, 1, 0, 0, 0, 0, -1, -1, 0, 1, "R5");
        send(8'h3C, 1, 0, 0, 0, 1, -1, -1, 0, 1, "R7");
        // R6 even and odd parity accepted, two stop bits
        send(8'h3C, 1, 1, 0, 0, 0, -1, -1, 0, 1, "R6");
        send(8'h81, 1, 1, 1, 1, 0, -1, -1, 0, 1, "R6");
        // R6 parity mismatch, even then odd
        send(8'h5A, 1, 1, 0, 0, 1, -1, -1, 0, 1, "R6");
        send(8'h07, 0, 1, 1, 0, 1, -1, -1, 0, 1, "R6");
        // R5 seven-bit mode, bit 7 of the source byte set
        send(8'hD5, 0, 0, 0, 0, 0, -1, -1, 0, 1, "R5");
        send(8'h2B, 0, 1, 0, 1, 0, -1, -1, 0, 1, "R5");
        // R8 low stop bit, single and second of two
        send(8'hF0, 1, 0, 0, 0, 0, 0, -1, 0, 1, "R8");
        send(8'h0F, 1, 0, 0, 1, 0, 1, -1, 0, 1, "R8");
        send(8'h66, 1, 0, 0, 1, 0, 0, -1, 0, 1, "R8");
        // R8 low stop beats bad parity
        send(8'h99, 1, 1, 0, 0, 1, 0, -1, 0, 1, "R8");
        // R4 single corrupted sample in a data bit and in the start bit
        send(8'h00, 1, 0, 0, 0, 0, -1, 3, 0, 1, "R4");
        send(8'hFF, 1, 1, 0, 0, 0, -1, 0, 0, 1, "R4");
        send(8'h55, 1, 1, 1, 0, 0, -1, 9, 0, 1, "R4");

        // R3 false start: low for less than half a bit
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            rx_line = 1'b0;
        end
        idle(200);
        send(8'hC3, 1, 0, 0, 0, 0, -1, -1, 0, 1, "R3");

        // R9 run off: frame ignored, then normal reception
        @(negedge clk);
        run = 1'b0;
        send(8'h12, 1, 0, 0, 0, 0, -1, -1, 0, 0, "R9");
        @(negedge clk);
        run = 1'b1;
        idle(10);
        send(8'h34, 1, 0, 0, 0, 0, -1, -1, 0, 1, "R9");

        // R10 line held low after a format error, then a clean frame
        send(8'hE7, 1, 0, 0, 0, 0, 0, -1, 400, 1, "R10");
        send(8'h18, 1, 0, 0, 0, 0, -1, -1, 0, 1, "R10");

        // R2 slower rate: bit time doubles
        rate_val = 16'd2048;
        idle(5);
        send(8'h6D, 1, 1, 0, 0, 0, -1, -1, 0, 1, "R2");
        rate_val = 16'd4096;
        idle(5);
        send(8'hB2, 1, 0, 0, 1, 0, -1, -1, 0, 1, "R2");

        idle(50);
        checks++;
        if (ex_cyc.size() != 0) begin
            errors++;
            $display("FAIL R2 %0d expected events never compared, expected 0", ex_cyc.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule